// File: doc/BRIEF.md
# Block-Transfer Register Slave for a Two-Wire Management Bus

This block is a slave on a two-wire management bus (SMBus/I2C electrical protocol). It holds a small bank of byte-wide configuration registers whose contents drive a parallel output bus. Software on a bus host reaches the bank only through multi-byte block transfers. A transfer always starts at register 0 and walks upward one register per byte. The host, not a length field, decides how many bytes move.

The clock and data lines are oversampled on a fast system clock. Each line passes through a synchronizer and a majority-free agreement filter. START, repeated START and STOP are decoded from the filtered levels. The slave pulls SDA low through an open-drain output enable, and it changes that enable only while SCL is low.

A write transfer sends the address with the direction bit clear, then a zero command byte, then a byte count that the slave acknowledges and discards, then the data. A read transfer sends the same address and command bytes, then a repeated START, then the address with the direction bit set. The slave then shifts out register data until the host withholds its acknowledge.

Top module: `smb_blk_slave`

## Requirements
- R1: After reset every register reads 0x00 on `regs_o` and `sda_oe_o` is 0 (SDA released).
- R2: The first byte after a START is the 7-bit address in bits 7:1, sent MSB first, with the direction bit in bit 0 (0 = write, 1 = read). The slave pulls SDA low in the ninth clock only when bits 7:1 equal `DEV_ADDR`. Otherwise it acknowledges nothing and changes no register until the next START or STOP.
- R3: In a write-direction transfer the byte after the address is a command byte that must equal 0x00 to be acknowledged. A nonzero command byte is not acknowledged, and every later byte is neither acknowledged nor stored until the next START or STOP.
- R4: The byte after an accepted command byte is a count. It is always acknowledged, and its value has no effect on how many data bytes are accepted.
- R5: Data bytes of a write transfer are acknowledged one by one. The first is stored in register 0 (`regs_o[7:0]`), and each later one is stored in the next higher register (register k in `regs_o[8k+7:8k]`).
- R6: The register pointer saturates at the last register. Further write bytes overwrite it, and further read bytes repeat it.
- R7: After a repeated START and an address byte with bit 0 set, the slave acknowledges and then sends register 0 MSB first. It advances to the next register each time the host acknowledges a byte.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START or STOP. A START or STOP always releases SDA.
- R9: `sda_oe_o` changes only while the filtered SCL is low, or as the release that follows a START or STOP.
- R10: A pulse on SCL or SDA shorter than three system clocks is ignored and neither adds a bit nor forms a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | NREG*8 | Register bank contents, register k in bits 8k+7:8k |

## Verification
The assertions assume the host never issues START or STOP while the slave is pulling SDA low. They also assume every bus level is held far longer than the synchronizer-plus-filter latency. Under those conditions every change of the output enable follows a filtered SCL fall. The stimulus holds each quarter of an SCL period for 20 system clocks. It returns SDA high only after the slave's acknowledge slot has closed. Its deliberate glitches last two clocks, one fewer than the filter needs, so they test rejection without breaking these assumptions.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_CNT,
      ST_WDATA,
      ST_RDATA,
      ST_IGNORE
   } blk_state_e;
endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
   parameter int SYNC_W   = 2,
   parameter int FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   if (SYNC_W < 2) begin : g_bad_sync
      $error("smb_line_filter: SYNC_W must be at least 2");
   end

   logic [SYNC_W-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_W-2:0], line_i};
   end

   generate
      if (FILT_LEN < 2) begin : g_bypass
         assign line_o = sync_q[SYNC_W-1];
      end else begin : g_agree
         logic [FILT_LEN-1:0] win_q;
         logic                lvl_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q <= '1;
               lvl_q <= 1'b1;
            end else begin
               win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_W-1]};
               if (&win_q)       lvl_q <= 1'b1;
               else if (~|win_q) lvl_q <= 1'b0;
            end
         end
         assign line_o = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_prev_q, sda_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_prev_q <= 1'b1;
         sda_prev_q <= 1'b1;
      end else begin
         scl_prev_q <= scl_lvl;
         sda_prev_q <= sda_lvl;
      end
   end

   assign scl_rise = !scl_prev_q && scl_lvl;
   assign scl_fall = scl_prev_q && !scl_lvl;
   assign start_ev = scl_prev_q && scl_lvl && sda_prev_q && !sda_lvl;
   assign stop_ev  = scl_prev_q && scl_lvl && !sda_prev_q && sda_lvl;
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
   import smb_blk_pkg::*;
#(
   parameter  int NREG  = 8,
   localparam int PTR_W = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [PTR_W-1:0]       ptr,
   input  logic [BYTE_W-1:0]      wr_data,
   output logic [BYTE_W-1:0]      rd_data,
   output logic [NREG*BYTE_W-1:0] regs_flat
);
   logic [BYTE_W-1:0] view [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= '0;
         else if (wr_en && ptr == PTR_W'(i))     q <= wr_data;
      end
      assign view[i]                         = q;
      assign regs_flat[i*BYTE_W +: BYTE_W]   = q;
   end

   assign rd_data = view[ptr];
endmodule

// File: rtl/smb_blk_fsm.sv
module smb_blk_fsm
   import smb_blk_pkg::*;
#(
   parameter  int           NREG     = 8,
   parameter  logic [6:0]   DEV_ADDR = 7'h3A,
   localparam int           PTR_W    = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_lvl,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_oe,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data,
   output logic [PTR_W-1:0]  ptr,
   output blk_state_e        state
);
   localparam logic [PTR_W-1:0] LAST    = PTR_W'(NREG - 1);
   localparam logic [3:0]       ACK_IDX = 4'd8;
   localparam logic [3:0]       END_IDX = 4'd9;

   blk_state_e        state_q;
   logic [3:0]        cnt_q;
   logic [BYTE_W-1:0] sh_q, tx_q;
   logic              ack_q, rw_q, mack_q, oe_q;
   logic [PTR_W-1:0]  ptr_q, ptr_inc;
   logic              addr_hit;
   logic [2:0]        bit_sel;

   assign ptr_inc  = (ptr_q == LAST) ? ptr_q : ptr_q + 1'b1;
   assign addr_hit = (sh_q[7:1] == DEV_ADDR);
   assign bit_sel  = 3'(4'd7 - cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         tx_q    <= '0;
         ack_q   <= 1'b0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         oe_q    <= 1'b0;
         ptr_q   <= '0;
      end else if (stop_ev) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (start_ev) begin
         state_q <= ST_ADDR;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else if (state_q != ST_IDLE) begin
         if (scl_rise) begin
            if (cnt_q < ACK_IDX) begin
               sh_q <= {sh_q[BYTE_W-2:0], sda_lvl};
            end else if (cnt_q == ACK_IDX) begin
               mack_q <= ~sda_lvl;
               if (state_q == ST_RDATA && !sda_lvl) ptr_q <= ptr_inc;
            end
            if (cnt_q != END_IDX) cnt_q <= cnt_q + 4'd1;
         end else if (scl_fall) begin
            if (cnt_q == ACK_IDX) begin
               case (state_q)
                  ST_ADDR: begin
                     ack_q <= addr_hit;
                     oe_q  <= addr_hit;
                     if (addr_hit) begin
                        ptr_q <= '0;
                        rw_q  <= sh_q[0];
                     end
                  end
                  ST_CMD: begin
                     ack_q <= (sh_q == '0);
                     oe_q  <= (sh_q == '0);
                  end
                  ST_CNT: begin
                     ack_q <= 1'b1;
                     oe_q  <= 1'b1;
                  end
                  ST_WDATA: begin
                     ack_q <= 1'b1;
                     oe_q  <= 1'b1;
                     ptr_q <= ptr_inc;
                  end
                  default: begin
                     ack_q <= 1'b0;
                     oe_q  <= 1'b0;
                  end
               endcase
            end else if (cnt_q == END_IDX) begin
               cnt_q <= '0;
               oe_q  <= 1'b0;
               case (state_q)
                  ST_ADDR: begin
                     if (!ack_q) state_q <= ST_IGNORE;
                     else if (rw_q) begin
                        state_q <= ST_RDATA;
                        tx_q    <= rd_data;
                        oe_q    <= ~rd_data[7];
                     end else state_q <= ST_CMD;
                  end
                  ST_CMD:  state_q <= ack_q ? ST_CNT : ST_IGNORE;
                  ST_CNT:  state_q <= ST_WDATA;
                  ST_RDATA: begin
                     if (mack_q) begin
                        tx_q <= rd_data;
                        oe_q <= ~rd_data[7];
                     end else state_q <= ST_IGNORE;
                  end
                  default: ;
               endcase
            end else if (state_q == ST_RDATA && cnt_q != 4'd0) begin
               oe_q <= ~tx_q[bit_sel];
            end
         end
      end
   end

   assign wr_en   = scl_fall && (cnt_q == ACK_IDX) && (state_q == ST_WDATA)
                    && !start_ev && !stop_ev;
   assign wr_data = sh_q;
   assign ptr     = ptr_q;
   assign sda_oe  = oe_q;
   assign state   = state_q;
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave
   import smb_blk_pkg::*;
#(
   parameter int         NREG        = 8,
   parameter logic [6:0] DEV_ADDR    = 7'h3A,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe_o,
   output logic [NREG*BYTE_W-1:0] regs_o
);
   localparam int PTR_W = $clog2(NREG);

   if (NREG < 2) begin : g_bad_depth
      $error("smb_blk_slave: NREG must be at least 2");
   end

   logic              scl_lvl, sda_lvl;
   logic              scl_rise, scl_fall, start_ev, stop_ev;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_data, rd_data;
   logic [PTR_W-1:0]  ptr;
   blk_state_e        fsm_state;

   smb_line_filter #(.SYNC_W(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_lvl));

   smb_line_filter #(.SYNC_W(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_lvl));

   smb_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev));

   smb_blk_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_ev(start_ev), .stop_ev(stop_ev), .sda_lvl(sda_lvl),
      .rd_data(rd_data), .sda_oe(sda_oe_o), .wr_en(wr_en),
      .wr_data(wr_data), .ptr(ptr), .state(fsm_state));

   smb_reg_bank #(.NREG(NREG)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr),
      .wr_data(wr_data), .rd_data(rd_data), .regs_flat(regs_o));
endmodule

// File: rtl/smb_blk_slave_chk.sv
module smb_blk_slave_chk
   import smb_blk_pkg::*;
#(
   parameter  int NREG  = 8,
   localparam int PTR_W = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_lvl,
   input  logic                   start_ev,
   input  logic                   stop_ev,
   input  logic                   sda_oe,
   input  logic                   wr_en,
   input  blk_state_e             state,
   input  logic [PTR_W-1:0]       ptr,
   input  logic [NREG*BYTE_W-1:0] regs
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

   // R9
   sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |->
         (!$past(scl_lvl) || $past(start_ev) || $past(stop_ev)));

   // R8
   bus_cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev || stop_ev) |=> !sda_oe);

   // R3
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IGNORE) |-> !sda_oe);

   // R5
   reg_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs));

   // R6
   ptr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ptr == LAST) |=> (ptr == LAST));
endmodule

bind smb_blk_slave smb_blk_slave_chk #(.NREG(NREG)) chk_i (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_ev(start_ev),
   .stop_ev(stop_ev), .sda_oe(sda_oe_o), .wr_en(wr_en),
   .state(fsm_state), .ptr(ptr), .regs(regs_o));

// File: tb/smb_blk_slave_tb_top.sv
`timescale 1ns/1ps
module smb_blk_slave_tb_top;
   localparam logic [6:0] ADDR = 7'h3A;
   localparam int         Q    = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1, gl_scl = 1'b0, gl_sda = 1'b0;
   logic scl_line, sda_line, sda_oe_o;
   logic [63:0] regs_o;

   always #10 clk = ~clk;

   assign scl_line = m_scl | gl_scl;
   assign sda_line = (m_sda ^ gl_sda) & ~sda_oe_o;

   smb_blk_slave #(.DEV_ADDR(ADDR)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .sda_oe_o(sda_oe_o), .regs_o(regs_o));

   logic [63:0] exp_q[$];
   logic [63:0] obs_q[$];
   string       tag_q[$];
   int          n_chk = 0, n_fail = 0, r9_viol = 0;
   bit          done = 0;
   logic [7:0]  mdl [8];
   logic        prev_oe = 1'b0;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_v(input logic [63:0] v, input string t);
      exp_q.push_back(v);
      tag_q.push_back(t);
   endtask

   function automatic logic [63:0] pack_mdl();
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = mdl[i];
      return r;
   endfunction

   task automatic chk_regs(input string t);
      expect_v(pack_mdl(), t);
      obs_q.push_back(regs_o);
   endtask

   task automatic chk_released(input string t);
      expect_v(64'd0, t);
      obs_q.push_back({63'd0, sda_oe_o});
   endtask

   // monitor: compares observations against the expected queue
   initial begin
      logic [63:0] o, e;
      string       t;
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0) begin
            o = obs_q.pop_front();
            n_chk++;
            if (exp_q.size() == 0) begin
               n_fail++;
               $display("FAIL unmatched observation actual=%0h expected=none", o);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (o !== e) begin
                  n_fail++;
                  $display("FAIL %s actual=%0h expected=%0h", t, o, e);
               end
            end
         end
      end
   end

   // R9 observer: output enable may move only while the clock line is low
   always @(negedge clk) begin
      if (rst_n && sda_oe_o !== prev_oe && scl_line) r9_viol++;
      prev_oe <= sda_oe_o;
   end

   task automatic put_bit(input logic b, input bit gl);
      tick(Q);
      m_sda = b;
      if (gl) begin
         tick(4); gl_scl = 1'b1; tick(2); gl_scl = 1'b0; tick(Q - 6);
      end else tick(Q);
      m_scl = 1'b1;
      if (gl) begin
         tick(Q/2); gl_sda = 1'b1; tick(2); gl_sda = 1'b0; tick(Q/2 - 2 + Q);
      end else tick(2*Q);
      m_scl = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1;
      tick(2*Q);
      m_scl = 1'b1;
      tick(Q);
      b = sda_line;
      tick(Q);
      m_scl = 1'b0;
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(Q);
      m_scl = 1'b1; tick(Q);
      m_sda = 1'b1; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, input logic exp_ack,
                            input string t, input bit gl);
      logic a;
      expect_v({63'd0, exp_ack}, t);
      for (int i = 7; i >= 0; i--) put_bit(v[i], gl);
      get_bit(a);
      obs_q.push_back({63'd0, ~a});
   endtask

   task automatic recv_byte(input logic [7:0] exp_v, input string t,
                            input logic mack);
      logic [7:0] v;
      logic       b;
      expect_v({56'd0, exp_v}, t);
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~mack, 1'b0);
      obs_q.push_back({56'd0, v});
   endtask

   task automatic open_read();
      bus_start();
      send_byte({ADDR, 1'b0}, 1'b1, "R2 read-setup address ack", 1'b0);
      send_byte(8'h00, 1'b1, "R3 read-setup command ack", 1'b0);
      bus_start();
      send_byte({ADDR, 1'b1}, 1'b1, "R7 read address ack", 1'b0);
   endtask

   initial begin
      logic b;
      for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
      tick(10);
      rst_n = 1'b1;
      tick(5);
      chk_regs("R1 reset register value");
      chk_released("R1 reset SDA released");

      // block write, count 3
      bus_start();
      send_byte({ADDR, 1'b0}, 1'b1, "R2 matching address ack", 1'b0);
      send_byte(8'h00, 1'b1, "R3 zero command ack", 1'b0);
      send_byte(8'd3, 1'b1, "R4 count ack", 1'b0);
      send_byte(8'hA1, 1'b1, "R5 data ack", 1'b0);
      send_byte(8'hB2, 1'b1, "R5 data ack", 1'b0);
      send_byte(8'hC3, 1'b1, "R5 data ack", 1'b0);
      bus_stop();
      mdl[0] = 8'hA1; mdl[1] = 8'hB2; mdl[2] = 8'hC3;
      tick(5);
      chk_regs("R5 sequential write from register 0");

      // count of 1 with four data bytes
      bus_start();
      send_byte({ADDR, 1'b0}, 1'b1, "R2 matching address ack", 1'b0);
      send_byte(8'h00, 1'b1, "R3 zero command ack", 1'b0);
      send_byte(8'd1, 1'b1, "R4 count ack", 1'b0);
      for (int i = 0; i < 4; i++) begin
         send_byte(8'(8'h11 * (i + 1)), 1'b1, "R4 byte beyond count ack", 1'b0);
         mdl[i] = 8'(8'h11 * (i + 1));
      end
      bus_stop();
      tick(5);
      chk_regs("R4 count value ignored");

      // foreign address
      bus_start();
      send_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, "R2 foreign address nack", 1'b0);
      send_byte(8'h00, 1'b0, "R2 byte after foreign address nack", 1'b0);
      send_byte(8'h55, 1'b0, "R2 byte after foreign address nack", 1'b0);
      bus_stop();
      tick(5);
      chk_regs("R2 foreign address leaves registers");

      // nonzero command
      bus_start();
      send_byte({ADDR, 1'b0}, 1'b1, "R2 matching address ack", 1'b0);
      send_byte(8'h05, 1'b0, "R3 nonzero command nack", 1'b0);
      send_byte(8'h66, 1'b0, "R3 byte after bad command nack", 1'b0);
      send_byte(8'h77, 1'b0, "R3 byte after bad command nack", 1'b0);
      bus_stop();
      tick(5);
      chk_regs("R3 bad command leaves registers");

      // block read of three bytes
      open_read();
      recv_byte(mdl[0], "R7 read register 0", 1'b1);
      recv_byte(mdl[1], "R7 read register 1", 1'b1);
      recv_byte(mdl[2], "R7 read register 2", 1'b0);
      bus_stop();
      tick(5);
      chk_released("R8 SDA released after read");

      // saturating write of ten bytes
      bus_start();
      send_byte({ADDR, 1'b0}, 1'b1, "R2 matching address ack", 1'b0);
      send_byte(8'h00, 1'b1, "R3 zero command ack", 1'b0);
      send_byte(8'd10, 1'b1, "R4 count ack", 1'b0);
      for (int i = 0; i < 10; i++) begin
         send_byte(8'(8'h80 + i), 1'b1, "R6 data ack past last register", 1'b0);
         mdl[(i > 7) ? 7 : i] = 8'(8'h80 + i);
      end
      bus_stop();
      tick(5);
      chk_regs("R6 last register overwritten");

      // saturating read of ten bytes
      open_read();
      for (int i = 0; i < 10; i++)
         recv_byte(mdl[(i > 7) ? 7 : i], "R6 read repeats last register", (i != 9));
      bus_stop();

      // early NACK, then an extra clock with no STOP yet
      open_read();
      recv_byte(mdl[0], "R7 first byte before early nack", 1'b0);
      expect_v(64'd1, "R8 line high after host nack");
      get_bit(b);
      obs_q.push_back({63'd0, b});
      bus_stop();

      // glitches on both lines inside data bits
      bus_start();
      send_byte({ADDR, 1'b0}, 1'b1, "R2 matching address ack", 1'b0);
      send_byte(8'h00, 1'b1, "R3 zero command ack", 1'b0);
      send_byte(8'd3, 1'b1, "R4 count ack", 1'b0);
      send_byte(8'h5A, 1'b1, "R10 glitched byte ack", 1'b1);
      send_byte(8'hC3, 1'b1, "R10 glitched byte ack", 1'b1);
      send_byte(8'h0F, 1'b1, "R10 glitched byte ack", 1'b1);
      bus_stop();
      mdl[0] = 8'h5A; mdl[1] = 8'hC3; mdl[2] = 8'h0F;
      tick(5);
      chk_regs("R10 glitches rejected");

      tick(20);
      expect_v(64'd0, "R9 output enable moved while clock high");
      obs_q.push_back(64'(r9_viol));
      tick(5);
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule